// File: doc/BRIEF.md
# Program Counter Sampling Register Block

This block is a register slave on an APB-style bus. It lets an external agent look at a running processor without stopping it. The core feeds in its live program counter, context ID, security state, exception level, register width, virtual machine ID, a halted flag, a profiling-prohibit flag and a power-up status. The block presents these values as memory-mapped sample registers.

Reading the low PC sample word takes a snapshot. In that same clock edge, the context ID, the virtualization context word and the upper 32 PC bits are copied into shadow registers. Later reads of those registers therefore stay consistent with the PC value just returned. The block also blocks sample accesses when the core is unpowered, double-locked or OS-locked. It reports its status and its feature level through read-only registers.

Top module: `pcsamp_regs`

## Requirements
- R1: The registers sit at these byte offsets:
  - 0x0A0: PC low.
  - 0x0A4: context ID.
  - 0x0A8: virtualization context.
  - 0x0AC: PC high.
  - 0x300: OS lock.
  - 0x314: status.
  - 0xFC4: feature ID 1. Bits 3:0 hold `PC_OFFSET_MODE`, where 0 tells the host that sampled PCs carry a pipeline offset (+8 for 32-bit and +4 for 16-bit instructions).
  - 0xFC8: feature ID. Bits 3:0 hold `IMPL_LEVEL`.
  - Any other offset reads zero.
- R2: A permitted read of PC low returns live PC bits 31:0. On the clock edge that ends that transfer, live context ID, virtualization context and PC bits 63:32 are latched. Later reads of 0x0A4, 0x0A8 and 0x0AC return the latched values even after the core inputs change.
- R3: When the halted flag or the profiling-prohibit flag is 1, a read of PC low returns 0xFFFFFFFF with no error, and no shadow register changes.
- R4: The virtualization context word has this layout:
  - bit 31: non-secure.
  - bit 30: exception level equals 2.
  - bit 29: exception level equals 3.
  - bit 28: 64-bit register width.
  - bits 7:0: VMID.
  - All other bits are zero.
- R5: The status register is readable at any time and never errors. Bit 0 is power-up, bit 5 is the OS lock and bit 6 is the double lock. The other bits are zero.
- R6: Sample access is not permitted while power-up is 0, double lock is 1 or the OS lock is set. A read of an implemented sample register then returns 0 with PSLVERR high, and it captures nothing.
- R7: Reset sets the OS lock. A write to 0x300 with bit 0 clear releases the lock, and a write with bit 0 set re-engages it.
- R8: Level 3 implements all four sample registers. Level 2 omits the virtualization context. Any other level implements none. An unimplemented sample register reads zero without error.
- R9: After reset all shadow registers are zero. PREADY is high in every access phase, so there are no wait states. Writes to any offset other than 0x300 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | AW | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Transfer error |
| core_pc | input | 64 | Live program counter |
| core_ctxid | input | 32 | Live context ID |
| core_nonsec | input | 1 | Core is in non-secure state |
| core_el | input | 2 | Exception level |
| core_wide | input | 1 | Core uses 64-bit registers |
| core_vmid | input | 8 | Virtual machine ID |
| core_halted | input | 1 | Core is in debug/halt state |
| prof_prohibit | input | 1 | Sampling is prohibited |
| core_powered | input | 1 | Core power domain is up |
| dbl_lock | input | 1 | OS double lock is set |

## Verification
The assertions assume that the bus holds `psel`, `paddr`, `pwrite` and `pwdata` steady across setup and access phases. They also assume that the core inputs stay steady during an access phase, because the returned PC and the captured companions come from the same cycle. The bench changes core inputs and gating flags only while the bus is idle, and it returns `psel` to idle after every transfer. It exercises the full layout with a level-3 instance and the reduced levels with level-2 and level-0 instances that share the same bus.

// File: rtl/pcsamp_regs.sv
module pcsamp_regs #(
  parameter int IMPL_LEVEL     = 3,
  parameter int PC_OFFSET_MODE = 0,
  parameter int AW             = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          pready,
  output logic          pslverr,
  input  logic [63:0]   core_pc,
  input  logic [31:0]   core_ctxid,
  input  logic          core_nonsec,
  input  logic [1:0]    core_el,
  input  logic          core_wide,
  input  logic [7:0]    core_vmid,
  input  logic          core_halted,
  input  logic          prof_prohibit,
  input  logic          core_powered,
  input  logic          dbl_lock
);
  localparam logic [AW-1:0] A_PCLO = AW'(12'h0A0);
  localparam logic [AW-1:0] A_CTX  = AW'(12'h0A4);
  localparam logic [AW-1:0] A_VC   = AW'(12'h0A8);
  localparam logic [AW-1:0] A_PCHI = AW'(12'h0AC);
  localparam logic [AW-1:0] A_OSL  = AW'(12'h300);
  localparam logic [AW-1:0] A_STS  = AW'(12'h314);
  localparam logic [AW-1:0] A_ID1  = AW'(12'hFC4);
  localparam logic [AW-1:0] A_ID0  = AW'(12'hFC8);
  localparam bit HAS_PC = (IMPL_LEVEL == 2) || (IMPL_LEVEL == 3);
  localparam bit HAS_VC = (IMPL_LEVEL == 3);

  logic        os_lock;
  logic [31:0] sh_ctx, sh_vc, sh_pchi, rdata;
  logic        unused_wdata;

  wire rd        = psel & penable & ~pwrite;
  wire wr        = psel & penable & pwrite;
  wire permit    = core_powered & ~dbl_lock & ~os_lock;
  wire no_sample = core_halted | prof_prohibit;
  wire hit_pclo  = paddr == A_PCLO;
  wire hit_ctx   = paddr == A_CTX;
  wire hit_vc    = paddr == A_VC;
  wire hit_pchi  = paddr == A_PCHI;
  wire hit_osl   = paddr == A_OSL;
  wire hit_sts   = paddr == A_STS;
  wire is_sample = (HAS_PC && (hit_pclo || hit_ctx || hit_pchi)) || (HAS_VC && hit_vc);
  wire capture   = rd & hit_pclo & HAS_PC & permit & ~no_sample;
  wire [31:0] vc_live = {core_nonsec, core_el == 2'd2, core_el == 2'd3, core_wide,
                         20'd0, core_vmid};

  assign unused_wdata = ^pwdata[31:1];
  assign pready  = 1'b1;
  assign pslverr = rd & is_sample & ~permit;
  assign prdata  = rd ? rdata : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_lock <= 1'b1;
      sh_ctx  <= '0;
      sh_vc   <= '0;
      sh_pchi <= '0;
    end else begin
      if (wr && hit_osl) os_lock <= pwdata[0];
      if (capture) begin
        sh_ctx  <= core_ctxid;
        sh_pchi <= core_pc[63:32];
        sh_vc   <= HAS_VC ? vc_live : 32'd0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (paddr)
      A_PCLO: if (HAS_PC && permit) rdata = no_sample ? 32'hFFFF_FFFF : core_pc[31:0];
      A_CTX:  if (HAS_PC && permit) rdata = sh_ctx;
      A_PCHI: if (HAS_PC && permit) rdata = sh_pchi;
      A_VC:   if (HAS_VC && permit) rdata = sh_vc;
      A_STS:  rdata = {25'd0, dbl_lock, os_lock, 4'd0, core_powered};
      A_ID1:  rdata = {28'd0, 4'(PC_OFFSET_MODE)};
      A_ID0:  rdata = {28'd0, 4'(IMPL_LEVEL)};
      default: rdata = '0;
    endcase
  end

  AST_SENTINEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit_pclo && no_sample) |=> $stable(sh_ctx) && $stable(sh_pchi) && $stable(sh_vc)); // R3
  AST_GATED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> prdata == 32'd0); // R6
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !permit) |=> $stable(sh_ctx) && $stable(sh_pchi) && $stable(sh_vc)); // R6
  AST_OSLOCK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_osl) |=> os_lock == $past(pwdata[0])); // R7
  AST_STATUS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit_sts) |-> !pslverr && prdata[0] == core_powered && prdata[6] == dbl_lock); // R5
  AST_VC_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit_vc) |-> prdata[27:8] == 20'd0); // R4
  AST_NO_VC_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_VC |-> sh_vc == 32'd0); // R8
  AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable) |-> pready); // R9
endmodule

// File: tb/test_pcsamp_regs.sv
module test_pcsamp_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [63:0] core_pc = '0;
  logic [31:0] core_ctxid = '0;
  logic core_nonsec = 0, core_wide = 0, core_halted = 0, prof_prohibit = 0;
  logic core_powered = 1, dbl_lock = 0;
  logic [1:0] core_el = '0;
  logic [7:0] core_vmid = '0;
  logic [31:0] prdata, prdata2, prdata0;
  logic pready, pready2, pready0, pslverr, pslverr2, pslverr0;
  logic [31:0] r_dat, r2_dat, r0_dat;
  logic r_err, r2_err, r0_err, r_rdy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pcsamp_regs #(.IMPL_LEVEL(3)) i_pcsamp_regs (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata,
    .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .core_pc, .core_ctxid, .core_nonsec, .core_el, .core_wide, .core_vmid,
    .core_halted, .prof_prohibit, .core_powered, .dbl_lock);
  pcsamp_regs #(.IMPL_LEVEL(2)) i_pcsamp_regs_l2 (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata,
    .prdata(prdata2), .pready(pready2), .pslverr(pslverr2),
    .core_pc, .core_ctxid, .core_nonsec, .core_el, .core_wide, .core_vmid,
    .core_halted, .prof_prohibit, .core_powered, .dbl_lock);
  pcsamp_regs #(.IMPL_LEVEL(0)) i_pcsamp_regs_l0 (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata,
    .prdata(prdata0), .pready(pready0), .pslverr(pslverr0),
    .core_pc, .core_ctxid, .core_nonsec, .core_el, .core_wide, .core_vmid,
    .core_halted, .prof_prohibit, .core_powered, .dbl_lock);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(logic [11:0] a, logic w, logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    #1;
    r_dat = prdata; r_err = pslverr; r_rdy = pready;
    r2_dat = prdata2; r2_err = pslverr2; r0_dat = prdata0; r0_err = pslverr0;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic t_reset;
    xfer(12'h314, 0, 0);
    chk("R7 lock set after reset", r_dat, 32'h21);
    chk("R9 pready", {31'd0, r_rdy}, 1);
    chk("R5 status no error", {31'd0, r_err}, 0);
    xfer(12'h0A4, 0, 0);
    chk("R6 locked read data", r_dat, 0);
    chk("R6 locked read error", {31'd0, r_err}, 1);
    chk("R8 level0 no error", {31'd0, r0_err}, 0);
  endtask

  task automatic t_unlock;
    xfer(12'h300, 1, 32'hFFFF_FFFE);
    xfer(12'h314, 0, 0);
    chk("R7 unlock", r_dat, 32'h01);
    xfer(12'h0A4, 0, 0);
    chk("R9 shadow zero after reset", r_dat, 0);
    chk("R6 permitted no error", {31'd0, r_err}, 0);
  endtask

  task automatic t_ids;
    xfer(12'hFC8, 0, 0);
    chk("R1 level id", r_dat, 3);
    chk("R1 level2 id", r2_dat, 2);
    xfer(12'hFC4, 0, 0);
    chk("R1 offset id", r_dat, 0);
    xfer(12'h200, 0, 0);
    chk("R1 unmapped zero", r_dat, 0);
  endtask

  task automatic t_capture;
    core_pc = 64'h1234_5678_9ABC_DEF0; core_ctxid = 32'hCAFE_0001;
    core_nonsec = 1; core_el = 2; core_wide = 1; core_vmid = 8'h5A;
    xfer(12'h0A0, 0, 0);
    chk("R2 live pc low", r_dat, 32'h9ABC_DEF0);
    core_pc = 64'hDEAD_BEEF_0000_0004; core_ctxid = 32'h1111_2222;
    core_nonsec = 0; core_el = 3; core_wide = 0; core_vmid = 8'hA5;
    xfer(12'h0A4, 0, 0);
    chk("R2 ctx latched", r_dat, 32'hCAFE_0001);
    chk("R2 level2 ctx latched", r2_dat, 32'hCAFE_0001);
    xfer(12'h0AC, 0, 0);
    chk("R2 pc high latched", r_dat, 32'h1234_5678);
    xfer(12'h0A8, 0, 0);
    chk("R4 vctx ns el2 wide", r_dat, 32'hD000_005A);
    chk("R8 level2 vctx absent", r2_dat, 0);
    chk("R8 level2 vctx no error", {31'd0, r2_err}, 0);
    xfer(12'h0A0, 0, 0);
    chk("R2 second pc low", r_dat, 32'h0000_0004);
    xfer(12'h0A8, 0, 0);
    chk("R4 vctx secure el3", r_dat, 32'h2000_00A5);
    xfer(12'h0AC, 0, 0);
    chk("R2 second pc high", r_dat, 32'hDEAD_BEEF);
    core_nonsec = 1; core_el = 1; core_wide = 1; core_vmid = 8'h01;
    xfer(12'h0A0, 0, 0);
    xfer(12'h0A8, 0, 0);
    chk("R4 vctx el1", r_dat, 32'h9000_0001);
    xfer(12'h0A0, 0, 0);
    chk("R8 level0 pc absent", r0_dat, 0);
  endtask

  task automatic t_sentinel;
    core_ctxid = 32'h0BAD_0BAD; core_pc = 64'h5555_5555_6666_6666;
    core_halted = 1;
    xfer(12'h0A0, 0, 0);
    chk("R3 halted sentinel", r_dat, 32'hFFFF_FFFF);
    chk("R3 halted no error", {31'd0, r_err}, 0);
    core_halted = 0; prof_prohibit = 1;
    xfer(12'h0A0, 0, 0);
    chk("R3 prohibit sentinel", r_dat, 32'hFFFF_FFFF);
    prof_prohibit = 0;
    xfer(12'h0A4, 0, 0);
    chk("R3 ctx not updated", r_dat, 32'h1111_2222);
    xfer(12'h0AC, 0, 0);
    chk("R3 pc high not updated", r_dat, 32'hDEAD_BEEF);
  endtask

  task automatic t_gate;
    core_powered = 0;
    xfer(12'h0A0, 0, 0);
    chk("R6 unpowered data", r_dat, 0);
    chk("R6 unpowered error", {31'd0, r_err}, 1);
    xfer(12'h314, 0, 0);
    chk("R5 status unpowered", r_dat, 0);
    core_powered = 1; dbl_lock = 1;
    xfer(12'h0A4, 0, 0);
    chk("R6 double lock error", {31'd0, r_err}, 1);
    xfer(12'h314, 0, 0);
    chk("R5 status double lock", r_dat, 32'h41);
    dbl_lock = 0;
    xfer(12'h0A4, 0, 0);
    chk("R6 no capture while gated", r_dat, 32'h1111_2222);
  endtask

  task automatic t_writes;
    xfer(12'h0A4, 1, 32'h7777_7777);
    xfer(12'h314, 1, 32'hFFFF_FFFF);
    xfer(12'h0A4, 0, 0);
    chk("R9 ctx write ignored", r_dat, 32'h1111_2222);
    xfer(12'h314, 0, 0);
    chk("R9 status write ignored", r_dat, 32'h01);
    xfer(12'h300, 1, 32'h1);
    xfer(12'h314, 0, 0);
    chk("R7 relock", r_dat, 32'h21);
    xfer(12'h0AC, 0, 0);
    chk("R6 oslock error", {31'd0, r_err}, 1);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_unlock;
    t_ids;
    t_capture;
    t_sentinel;
    t_gate;
    t_writes;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule